// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters, each split into a low byte and a high byte. Each one picks one of four counting modes and one of two count sources: a machine-cycle tick, which is the clock divided by `MC_DIV` (12 by default), or falling edges on its own external count pin. A run bit, a gate bit and an external gate pin decide when counting is enabled. When the gate bit is set, counting follows the gate pin, so the width of a high pulse on that pin can be measured.

Software works through a small register interface of byte-wide registers. Writes happen on a clock edge and reads are combinational. There is one control register (run bits and overflow flags), one configuration register (mode, source select and gate bit per timer) and the four count bytes. The block outputs two sticky overflow flags for an interrupt controller, which clears them through two acknowledge inputs. It also outputs a one-cycle pulse on every timer 1 overflow for a serial baud generator. In split mode, timer 0 becomes two independent 8-bit counters. Timer 0's high byte then takes over timer 1's run bit and flag, while timer 1 keeps counting only to drive the baud pulse.

Top module: `tc_timer_unit`

## Requirements
- R1: After reset, every count byte, the configuration register, both run bits, both flags and the overflow pulse are 0.
- R2: The machine-cycle tick occurs on every `MC_DIV`-th rising clock edge, first on the `MC_DIV`-th edge after reset is released. A timer whose source select is 0 advances by one on each tick while it is enabled.
- R3: A timer counts only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Otherwise it holds its count. Setting the run bit does not alter the count bytes.
- R4: With source select 1, a timer counts one event per 1-to-0 change of its count pin. The pin is sampled only on machine-cycle ticks, and the previous sample starts at 0. This gives at most one count per machine cycle, however often the pin toggles between ticks.
- R5: Mode code 1 counts the 16-bit value {high, low}. A roll-over from 0xFFFF to 0x0000 sets the timer's flag.
- R6: Mode code 0 counts the 13-bit value {high, low[4:0]}. Bits 7..5 of the low byte keep their last written value. A roll-over of the 13-bit value to 0 sets the flag.
- R7: Mode code 2 counts the low byte alone. On the tick that would roll it past 0xFF, it loads the high byte instead and sets the flag. The high byte is left unchanged.
- R8: Timer 1 in mode code 3 holds both of its count bytes.
- R9: With timer 0 in mode code 3, its low byte counts as an 8-bit counter under timer 0's run bit, gate, source select and flag. Its high byte counts machine-cycle ticks while timer 1's run bit is 1, and its 0xFF to 0x00 roll-over sets timer 1's flag.
- R10: While timer 0 is in mode code 3, timer 1 in modes 0 to 2 counts with its run bit ignored (its gate and source select still apply), and its overflows do not set timer 1's flag.
- R11: `t1_ovf_pulse` is high for exactly one cycle, the cycle after each timer 1 overflow edge, in every mode of timer 0.
- R12: A flag is cleared by its acknowledge input or by a control-register write with its bit at 0. Writing 1 leaves the flag as it is. An overflow on the same edge wins over either kind of clear.
- R13: Register addresses are: 0 control ({flag1, flag0, run1, run0} in bits 3..0, bits 7..4 read 0); 1 configuration (bits 3..0 timer 0 and bits 7..4 timer 1, each nibble {gate, source select, mode[1:0]}); 2 and 3 timer 0 low and high; 4 and 5 timer 1 low and high; 6 and 7 read 0. A write to either count byte of a timer takes the written value and cancels that timer's count step on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| ext_gate0 | input | 1 | Gate pin of timer 0 |
| ext_gate1 | input | 1 | Gate pin of timer 1 |
| ext_cnt0 | input | 1 | External count pin of timer 0 |
| ext_cnt1 | input | 1 | External count pin of timer 1 |
| irq_ack0 | input | 1 | Clears timer 0 flag |
| irq_ack1 | input | 1 | Clears timer 1 flag |
| ovf_flag0 | output | 1 | Timer 0 overflow flag |
| ovf_flag1 | output | 1 | Timer 1 overflow flag (timer 0 high byte in split mode) |
| t1_ovf_pulse | output | 1 | One-cycle pulse per timer 1 overflow |

## Verification
Each counting mode is started from a preload a few ticks below its roll-over point and run for an exact number of machine cycles, set by run-bit writes aligned to the tick phase. The resulting bytes then tell the 16-bit, 13-bit and reload carries apart, show whether the upper low-byte bits are kept, and show whether the reload source stays unchanged. Gate-low and gate-high runs of equal length separate the gating rule from plain run control. A pin pattern that includes a burst of toggles between two ticks shows that counting happens once per sampled falling edge. Split-mode runs with timer 1 parked, and then released, show which flag each byte drives and whether timer 1 only pulses. Collisions placed exactly on a tick edge (acknowledge against overflow, byte write against a count step) expose the priority rules.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int BYTE_W   = 8;
    localparam int PRE_W    = 5;
    localparam int CNT13_W  = BYTE_W + PRE_W;
    localparam int CNT16_W  = 2 * BYTE_W;
    localparam int ADDR_W   = 3;

    typedef enum logic [1:0] {
        MODE_13B     = 2'd0,
        MODE_16B     = 2'd1,
        MODE_RELOAD8 = 2'd2,
        MODE_SPLIT   = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   csel;
        tmode_e mode;
    } tcfg_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_T0L  = 3'd2;
    localparam logic [ADDR_W-1:0] A_T0H  = 3'd3;
    localparam logic [ADDR_W-1:0] A_T1L  = 3'd4;
    localparam logic [ADDR_W-1:0] A_T1H  = 3'd5;
endpackage

// File: rtl/tc_mc_tick.sv
module tc_mc_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/tc_edge_sense.sv
module tc_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic pin,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (sample)
            prev_q <= pin;
    end

    assign fall = sample & prev_q & ~pin;
endmodule

// File: rtl/tc_step.sv
module tc_step
    import tc_pkg::*;
(
    input  tmode_e            mode,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic              en_lo,
    input  logic              en_hi,
    output logic [BYTE_W-1:0] lo_nx,
    output logic [BYTE_W-1:0] hi_nx,
    output logic              ovf_main,
    output logic              ovf_hi
);
    logic [CNT13_W-1:0] sum13;
    logic [CNT16_W-1:0] sum16;

    assign sum13 = {hi, lo[PRE_W-1:0]} + CNT13_W'(1);
    assign sum16 = {hi, lo} + CNT16_W'(1);

    always_comb begin
        lo_nx    = lo;
        hi_nx    = hi;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        unique case (mode)
            MODE_13B: begin
                if (en_lo) begin
                    lo_nx    = {lo[BYTE_W-1:PRE_W], sum13[PRE_W-1:0]};
                    hi_nx    = sum13[CNT13_W-1:PRE_W];
                    ovf_main = &{hi, lo[PRE_W-1:0]};
                end
            end
            MODE_16B: begin
                if (en_lo) begin
                    lo_nx    = sum16[BYTE_W-1:0];
                    hi_nx    = sum16[CNT16_W-1:BYTE_W];
                    ovf_main = &{hi, lo};
                end
            end
            MODE_RELOAD8: begin
                if (en_lo) begin
                    ovf_main = &lo;
                    lo_nx    = (&lo) ? hi : lo + 1'b1;
                end
            end
            MODE_SPLIT: begin
                if (en_lo) begin
                    lo_nx    = lo + 1'b1;
                    ovf_main = &lo;
                end
                if (en_hi) begin
                    hi_nx  = hi + 1'b1;
                    ovf_hi = &hi;
                end
            end
        endcase
    end
endmodule

// File: rtl/tc_timer_unit.sv
module tc_timer_unit
    import tc_pkg::*;
#(
    parameter int MC_DIV = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ext_gate0,
    input  logic              ext_gate1,
    input  logic              ext_cnt0,
    input  logic              ext_cnt1,
    input  logic              irq_ack0,
    input  logic              irq_ack1,
    output logic              ovf_flag0,
    output logic              ovf_flag1,
    output logic              t1_ovf_pulse
);
    localparam int NT = 2;

    logic              mc_tick;
    logic [NT-1:0]     cnt_pins, gate_pins, fall_evt, src_evt, gate_ok, ack;
    tcfg_t             cfg_q [NT];
    logic [NT-1:0]     run_q, flag_q, flag_set;
    logic [BYTE_W-1:0] t0_lo, t0_hi, t1_lo, t1_hi;
    logic              pulse_q;

    assign cnt_pins  = {ext_cnt1, ext_cnt0};
    assign gate_pins = {ext_gate1, ext_gate0};
    assign ack       = {irq_ack1, irq_ack0};

    tc_mc_tick #(.DIV(MC_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (mc_tick)
    );

    for (genvar i = 0; i < NT; i++) begin : g_src
        tc_edge_sense u_sense (
            .clk   (clk),
            .rst_n (rst_n),
            .sample(mc_tick),
            .pin   (cnt_pins[i]),
            .fall  (fall_evt[i])
        );
        assign src_evt[i] = cfg_q[i].csel ? fall_evt[i] : mc_tick;
        assign gate_ok[i] = ~cfg_q[i].gate | gate_pins[i];
    end

    // register decode
    logic wr_ctrl, wr_cfg, wr_t0l, wr_t0h, wr_t1l, wr_t1h, wr_t0, wr_t1;
    assign wr_ctrl = reg_wr & (reg_addr == A_CTRL);
    assign wr_cfg  = reg_wr & (reg_addr == A_CFG);
    assign wr_t0l  = reg_wr & (reg_addr == A_T0L);
    assign wr_t0h  = reg_wr & (reg_addr == A_T0H);
    assign wr_t1l  = reg_wr & (reg_addr == A_T1L);
    assign wr_t1h  = reg_wr & (reg_addr == A_T1H);
    assign wr_t0   = wr_t0l | wr_t0h;
    assign wr_t1   = wr_t1l | wr_t1h;

    // enables
    logic split, t1_parked, en0_lo, en0_hi, en1;
    assign split     = (cfg_q[0].mode == MODE_SPLIT);
    assign t1_parked = (cfg_q[1].mode == MODE_SPLIT);
    assign en0_lo    = src_evt[0] & run_q[0] & gate_ok[0];
    assign en0_hi    = mc_tick & run_q[1];
    assign en1       = src_evt[1] & (split | run_q[1]) & gate_ok[1] & ~t1_parked;

    logic [BYTE_W-1:0] s0_lo, s0_hi, s1_lo, s1_hi;
    logic              s0_ovf, s0_ovf_hi, s1_ovf, s1_ovf_hi;

    tc_step u_step0 (
        .mode    (cfg_q[0].mode),
        .lo      (t0_lo),
        .hi      (t0_hi),
        .en_lo   (en0_lo),
        .en_hi   (en0_hi),
        .lo_nx   (s0_lo),
        .hi_nx   (s0_hi),
        .ovf_main(s0_ovf),
        .ovf_hi  (s0_ovf_hi)
    );

    tc_step u_step1 (
        .mode    (cfg_q[1].mode),
        .lo      (t1_lo),
        .hi      (t1_hi),
        .en_lo   (en1),
        .en_hi   (1'b0),
        .lo_nx   (s1_lo),
        .hi_nx   (s1_hi),
        .ovf_main(s1_ovf),
        .ovf_hi  (s1_ovf_hi)
    );

    logic ovf0_ev, ovf0h_ev, ovf1_ev;
    assign ovf0_ev     = s0_ovf & ~wr_t0;
    assign ovf0h_ev    = s0_ovf_hi & ~wr_t0;
    assign ovf1_ev     = (s1_ovf | s1_ovf_hi) & ~wr_t1;
    assign flag_set[0] = ovf0_ev;
    assign flag_set[1] = split ? ovf0h_ev : ovf1_ev;

    // count bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t0_lo <= '0;
            t0_hi <= '0;
        end else if (wr_t0) begin
            if (wr_t0l) t0_lo <= reg_wdata;
            if (wr_t0h) t0_hi <= reg_wdata;
        end else begin
            t0_lo <= s0_lo;
            t0_hi <= s0_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t1_lo <= '0;
            t1_hi <= '0;
        end else if (wr_t1) begin
            if (wr_t1l) t1_lo <= reg_wdata;
            if (wr_t1h) t1_hi <= reg_wdata;
        end else begin
            t1_lo <= s1_lo;
            t1_hi <= s1_hi;
        end
    end

    // configuration, run, flags, pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q[0] <= '0;
            cfg_q[1] <= '0;
            run_q    <= '0;
            flag_q   <= '0;
            pulse_q  <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_q[0] <= tcfg_t'(reg_wdata[3:0]);
                cfg_q[1] <= tcfg_t'(reg_wdata[7:4]);
            end
            if (wr_ctrl)
                run_q <= reg_wdata[1:0];
            for (int i = 0; i < NT; i++)
                flag_q[i] <= flag_set[i] |
                             (flag_q[i] & ~ack[i] & ~(wr_ctrl & ~reg_wdata[2+i]));
            pulse_q <= ovf1_ev;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {4'b0000, flag_q, run_q};
            A_CFG:   reg_rdata = {cfg_q[1], cfg_q[0]};
            A_T0L:   reg_rdata = t0_lo;
            A_T0H:   reg_rdata = t0_hi;
            A_T1L:   reg_rdata = t1_lo;
            A_T1H:   reg_rdata = t1_hi;
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_flag0    = flag_q[0];
    assign ovf_flag1    = flag_q[1];
    assign t1_ovf_pulse = pulse_q;
endmodule

// File: rtl/tc_timer_unit_chk.sv
module tc_timer_unit_chk #(
    parameter int MC_DIV = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       mc_tick,
    input logic [1:0] t0_mode,
    input logic [1:0] t1_mode,
    input logic       run0,
    input logic [7:0] t0_lo,
    input logic [7:0] t0_hi,
    input logic [7:0] t1_lo,
    input logic [7:0] t1_hi,
    input logic       s0_ovf,
    input logic       ovf_flag0,
    input logic       t1_ovf_pulse
);
    localparam int PW = (MC_DIV > 2) ? $clog2(MC_DIV) : 1;

    logic [PW-1:0] ph;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    ph <= '0;
        else if (ph == PW'(MC_DIV-1))  ph <= '0;
        else                           ph <= ph + 1'b1;
    end

    logic wr_t0, wr_t0h, wr_t0l, wr_t1;
    assign wr_t0l = reg_wr && (reg_addr == 3'd2);
    assign wr_t0h = reg_wr && (reg_addr == 3'd3);
    assign wr_t0  = wr_t0l || wr_t0h;
    assign wr_t1  = reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5);

    p_tick_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick == (ph == PW'(MC_DIV-1)));

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !wr_t0 && t0_mode != 2'd3) |=> ($stable(t0_lo) && $stable(t0_hi)));

    p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode == 2'd0 && !wr_t0l) |=> $stable(t0_lo[7:5]));

    p_reload_src_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_mode == 2'd2 && !wr_t0h) |=> $stable(t0_hi));

    p_t1_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_mode == 2'd3 && !wr_t1) |=> ($stable(t1_lo) && $stable(t1_hi)));

    p_pulse_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        t1_ovf_pulse |-> $past(mc_tick));

    p_ovf_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_ovf && !wr_t0) |=> ovf_flag0);
endmodule

bind tc_timer_unit tc_timer_unit_chk #(.MC_DIV(MC_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .mc_tick     (mc_tick),
    .t0_mode     (cfg_q[0].mode),
    .t1_mode     (cfg_q[1].mode),
    .run0        (run_q[0]),
    .t0_lo       (t0_lo),
    .t0_hi       (t0_hi),
    .t1_lo       (t1_lo),
    .t1_hi       (t1_hi),
    .s0_ovf      (s0_ovf),
    .ovf_flag0   (ovf_flag0),
    .t1_ovf_pulse(t1_ovf_pulse)
);

// File: tb/tb_tc_timer_unit.sv
module tb_tc_timer_unit;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ext_gate0 = 1'b0, ext_gate1 = 1'b0;
    logic       ext_cnt0 = 1'b0, ext_cnt1 = 1'b0;
    logic       irq_ack0 = 1'b0, irq_ack1 = 1'b0;
    logic       ovf_flag0, ovf_flag1, t1_ovf_pulse;

    always #4 clk = ~clk;

    tc_timer_unit #(.MC_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_gate0(ext_gate0), .ext_gate1(ext_gate1),
        .ext_cnt0(ext_cnt0), .ext_cnt1(ext_cnt1),
        .irq_ack0(irq_ack0), .irq_ack1(irq_ack1),
        .ovf_flag0(ovf_flag0), .ovf_flag1(ovf_flag1),
        .t1_ovf_pulse(t1_ovf_pulse)
    );

    int ecnt = 0;
    int pcnt = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    always @(posedge clk) if (rst_n && t1_ovf_pulse) pcnt <= pcnt + 1;

    // scoreboard
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];
    event  mon_ev;

    initial begin
        forever begin
            @(mon_ev);
            while (sbq.size() > 0) begin
                item_t      it;
                logic [7:0] got;
                it = sbq.pop_front();
                case (it.kind)
                    0:       got = reg_rdata;
                    1:       got = {7'b0, ovf_flag0};
                    2:       got = {7'b0, ovf_flag1};
                    default: got = pcnt[7:0];
                endcase
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
                end
            end
        end
    end

    // all tasks start and end at a falling edge
    task automatic chk(input int kind, input logic [2:0] a, input logic [7:0] exp,
                       input string tag);
        reg_addr = a;
        #1;
        sbq.push_back('{kind: kind, exp: exp, tag: tag});
        -> mon_ev;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // write lands on the edge just after a tick edge
    task automatic wr_al(input logic [2:0] a, input logic [7:0] d);
        while (ecnt % DIV != 0) @(negedge clk);
        wr(a, d);
    endtask

    // exactly k ticks between the start and stop writes
    task automatic run_win(input logic [2:0] a, input logic [7:0] start_v,
                           input logic [7:0] stop_v, input int k);
        wr_al(a, start_v);
        repeat ((k - 1) * DIV) @(negedge clk);
        wr_al(a, stop_v);
    endtask

    task automatic to_pre_tick();
        while (ecnt % DIV != DIV - 1) @(negedge clk);
    endtask

    task automatic pin_pulse(input bit burst);
        ext_cnt0 = 1'b1;
        repeat (2 * DIV) @(negedge clk);
        if (burst) begin
            for (int j = 0; j < 2; j++) begin
                ext_cnt0 = 1'b0; repeat (2) @(negedge clk);
                ext_cnt0 = 1'b1; repeat (2) @(negedge clk);
            end
        end
        ext_cnt0 = 1'b0;
        repeat (2 * DIV) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(0, 3'd0, 8'h00, "R1 ctrl");
        chk(0, 3'd1, 8'h00, "R1 cfg");
        chk(0, 3'd2, 8'h00, "R1 t0 low");
        chk(0, 3'd5, 8'h00, "R1 t1 high");
        chk(1, 3'd0, 8'h00, "R1 flag0");
        chk(2, 3'd0, 8'h00, "R1 flag1");

        // R5/R2 16-bit mode, exact tick count
        wr(3'd1, 8'h01);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        run_win(3'd0, 8'h01, 8'h0C, 3);
        chk(0, 3'd2, 8'h01, "R2 t0 low after 3 ticks");
        chk(0, 3'd3, 8'h00, "R5 t0 high after wrap");
        chk(1, 3'd0, 8'h01, "R5 flag0 on wrap");
        chk(0, 3'd0, 8'h04, "R13 ctrl readback");

        // R12 overflow beats acknowledge on same edge
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr_al(3'd0, 8'h0D);
        to_pre_tick();
        irq_ack0 = 1'b1;
        @(negedge clk);
        irq_ack0 = 1'b0;
        wr_al(3'd0, 8'h0C);
        chk(1, 3'd0, 8'h01, "R12 overflow wins over ack");
        chk(0, 3'd2, 8'h00, "R12 count wrapped");
        irq_ack0 = 1'b1;
        @(negedge clk);
        irq_ack0 = 1'b0;
        chk(1, 3'd0, 8'h00, "R12 ack clears flag0");

        // R6 13-bit mode
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        run_win(3'd0, 8'h01, 8'h0C, 3);
        chk(0, 3'd2, 8'hE1, "R6 low keeps upper bits");
        chk(0, 3'd3, 8'h00, "R6 high after wrap");
        chk(1, 3'd0, 8'h01, "R6 flag0 on wrap");
        wr(3'd0, 8'h08);
        chk(1, 3'd0, 8'h00, "R12 write 0 clears flag0");

        // R7 reload mode
        wr(3'd1, 8'h02);
        wr(3'd3, 8'hF0); wr(3'd2, 8'hFE);
        run_win(3'd0, 8'h01, 8'h0C, 3);
        chk(0, 3'd2, 8'hF1, "R7 low reloaded then counted");
        chk(0, 3'd3, 8'hF0, "R7 high unchanged");
        chk(1, 3'd0, 8'h01, "R7 flag0 on reload");
        wr(3'd0, 8'h00);

        // R3 gating
        wr(3'd1, 8'h09);
        wr(3'd2, 8'h10); wr(3'd3, 8'h00);
        run_win(3'd0, 8'h01, 8'h00, 5);
        chk(0, 3'd2, 8'h10, "R3 gate pin low holds");
        ext_gate0 = 1'b1;
        run_win(3'd0, 8'h01, 8'h00, 5);
        chk(0, 3'd2, 8'h15, "R3 gate pin high counts");
        ext_gate0 = 1'b0;

        // R4 external count pin
        wr(3'd1, 8'h05);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h01);
        pin_pulse(1'b0);
        pin_pulse(1'b1);
        pin_pulse(1'b0);
        wr(3'd0, 8'h00);
        chk(0, 3'd2, 8'h03, "R4 one count per sampled fall");

        // R9/R8 split mode, timer 1 parked
        wr(3'd1, 8'h33);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFE);
        wr(3'd4, 8'h55); wr(3'd5, 8'hAA);
        run_win(3'd0, 8'h03, 8'h0C, 2);
        chk(0, 3'd2, 8'h01, "R9 split low byte");
        chk(0, 3'd3, 8'h00, "R9 split high byte");
        chk(1, 3'd0, 8'h01, "R9 low byte sets flag0");
        chk(2, 3'd0, 8'h01, "R9 high byte sets flag1");
        chk(0, 3'd4, 8'h55, "R8 t1 low held");
        chk(0, 3'd5, 8'hAA, "R8 t1 high held");

        // R10/R11 timer 1 counts for the pulse only
        wr(3'd0, 8'h00);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        chk(3, 3'd0, 8'h00, "R11 no pulse yet");
        run_win(3'd1, 8'h13, 8'h33, 2);
        chk(0, 3'd4, 8'h01, "R10 t1 counts with run bit 0");
        chk(0, 3'd5, 8'h00, "R10 t1 high wrapped");
        chk(2, 3'd0, 8'h00, "R10 no flag1 from timer 1");
        chk(3, 3'd0, 8'h01, "R11 one pulse");
        chk(0, 3'd3, 8'h00, "R9 high byte needs run1");

        // R11 pulse plus flag in normal timer 0 mode
        wr(3'd1, 8'h21);
        wr(3'd5, 8'hFF); wr(3'd4, 8'hFE);
        run_win(3'd0, 8'h02, 8'h0C, 2);
        chk(0, 3'd4, 8'hFF, "R7 t1 reload value");
        chk(2, 3'd0, 8'h01, "R11 flag1 set in normal mode");
        chk(3, 3'd0, 8'h02, "R11 second pulse");

        // R13 write beats count step on a tick edge
        wr(3'd2, 8'h3F);
        wr_al(3'd0, 8'h01);
        to_pre_tick();
        wr(3'd2, 8'h40);
        wr_al(3'd0, 8'h00);
        chk(0, 3'd2, 8'h40, "R13 write cancels count step");
        chk(0, 3'd6, 8'h00, "R13 unused address reads 0");
        chk(0, 3'd1, 8'h21, "R13 cfg readback");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule